// File: doc/BRIEF.md
# Page Table Entry Access Checker

This unit sits beside an address translation path and judges one memory access against one 4-byte page table entry that maps a 4 KB virtual page. For each request it receives the entry, the virtual address, and two attributes of the access: read or write, and user or supervisor. It returns either a fault with a cause code, or the physical address that the access resolves to. Instruction fetches have no permission bit of their own, so the requester presents them as reads.

On a legal access the unit also produces the entry as it should look in memory afterwards, with the accessed flag set and, for a write, the dirty flag set. Hardware only ever sets these flags; software clears them. The updated entry is offered for write-back only when one of the two flags actually changes. This spares the memory system a redundant store on the common repeated-access case. All results are registered and appear one clock after the request.

Entry layout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bits 31..12 frame base. The other bits are carried through untouched.

Top module: `pte_access_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge.
- R2: `rsp_valid` is high in the cycle after a clock edge that sampled `req_valid` high and low otherwise; when `rsp_valid` is low, all other outputs are 0.
- R3: When the entry's present bit (bit 0) is 0, the response faults with cause 2'b01 (not present) whatever the other entry bits, the access type and the privilege are.
- R4: A present entry with writable bit (bit 1) at 0, receiving a write that passes the privilege check, faults with cause 2'b10 (write protect).
- R5: A present entry with user bit (bit 2) at 0, receiving a user access, faults with cause 2'b11 (privilege); this cause wins over write protect. A faulting response has `rsp_fault` high, `rsp_paddr` 0 and `wb_valid` 0.
- R6: A legal access responds with `rsp_fault` 0, cause 2'b00 and `rsp_paddr` equal to entry bits 31..12 followed by virtual address bits 11..0.
- R7: On a legal access `wb_entry` equals the input entry with bit 5 (accessed) set, and with bit 6 (dirty) set if the access is a write; all other bits are copied unchanged and a flag already set stays set.
- R8: `wb_valid` is high only for a legal access whose entry lacked the accessed flag, or lacked the dirty flag on a write; a read of an already-accessed entry, or a write of an accessed and dirty entry, gives `wb_valid` 0 and `wb_entry` 0.
- R9: A supervisor access ignores the user bit, and a read ignores the writable bit: both succeed on a present entry with bits 1 and 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read or fetch |
| req_user | input | 1 | 1 for user access, 0 for supervisor |
| req_entry | input | 32 | Page table entry for the page |
| req_vaddr | input | 32 | Virtual address of the access |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write protect, 3 privilege |
| rsp_paddr | output | 32 | Physical address on a legal access |
| wb_valid | output | 1 | Updated entry must be stored back |
| wb_entry | output | 32 | Updated entry on a legal access |

## Verification
The unit holds no state beyond its output registers, so any wrong internal value surfaces at the ports in the very cycle after the request that caused it. A wrong priority between checks shows as a mismatched cause code on entries that break two rules at once, a wrong flag merge shows as a cleared or missing bit in the write-back entry, and a wrong change test shows as a write-back pulse on an access that alters nothing, or a missing one when a flag flips. The bench compares every output against a behavioural model on every clock, with directed corner entries followed by a long random mix that includes idle cycles.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  // Bit positions that the page-table memory format fixes
  localparam int unsigned PTE_BIT_PRESENT  = 0;
  localparam int unsigned PTE_BIT_WRITABLE = 1;
  localparam int unsigned PTE_BIT_USER     = 2;
  localparam int unsigned PTE_BIT_ACCESSED = 5;
  localparam int unsigned PTE_BIT_DIRTY    = 6;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_ABSENT  = 2'b01,
    CAUSE_WPROT   = 2'b10,
    CAUSE_PRIV    = 2'b11
  } pte_cause_e;

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_chk_pkg::*;
(
  input  logic       present,
  input  logic       writable,
  input  logic       user_ok,
  input  logic       is_write,
  input  logic       is_user,
  output pte_cause_e cause
);

  // Priority: absent page, then privilege, then write protection
  always_comb begin
    if (!present)
      cause = CAUSE_ABSENT;
    else if (is_user && !user_ok)
      cause = CAUSE_PRIV;
    else if (is_write && !writable)
      cause = CAUSE_WPROT;
    else
      cause = CAUSE_NONE;
  end

endmodule

// File: rtl/pte_flag_update.sv
module pte_flag_update
  import pte_chk_pkg::*;
#(
  parameter int unsigned ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry_in,
  input  logic               is_write,
  output logic [ENTRY_W-1:0] entry_out,
  output logic               flags_changed
);

  logic [ENTRY_W-1:0] set_mask;

  // Flags are only ever ORed in; clearing belongs to software
  always_comb begin
    set_mask                   = '0;
    set_mask[PTE_BIT_ACCESSED] = 1'b1;
    set_mask[PTE_BIT_DIRTY]    = is_write;
  end

  assign entry_out     = entry_in | set_mask;
  assign flags_changed = |(set_mask & ~entry_in);

endmodule

// File: rtl/pte_addr_form.sv
module pte_addr_form #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-PAGE_SHIFT-1:0] frame,
  input  logic [PAGE_SHIFT-1:0]        offset,
  output logic [ADDR_W-1:0]            paddr
);

  assign paddr = {frame, offset};

endmodule

// File: rtl/pte_access_unit.sv
module pte_access_unit
  import pte_chk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] req_entry,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_entry
);

  localparam int unsigned FRAME_W = ADDR_W - PAGE_SHIFT;

  pte_cause_e        cause_c;
  logic              legal_c;
  logic [ADDR_W-1:0] paddr_c;
  logic [ADDR_W-1:0] entry_upd_c;
  logic              changed_c;
  logic              unused_vaddr_hi;

  // Upper virtual address bits are replaced by the frame base
  assign unused_vaddr_hi = ^req_vaddr[ADDR_W-1:PAGE_SHIFT];

  pte_perm_eval i_perm (
    .present  (req_entry[PTE_BIT_PRESENT]),
    .writable (req_entry[PTE_BIT_WRITABLE]),
    .user_ok  (req_entry[PTE_BIT_USER]),
    .is_write (req_write),
    .is_user  (req_user),
    .cause    (cause_c)
  );

  pte_flag_update #(.ENTRY_W(ADDR_W)) i_flags (
    .entry_in      (req_entry),
    .is_write      (req_write),
    .entry_out     (entry_upd_c),
    .flags_changed (changed_c)
  );

  pte_addr_form #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) i_addr (
    .frame  (req_entry[ADDR_W-1:ADDR_W-FRAME_W]),
    .offset (req_vaddr[PAGE_SHIFT-1:0]),
    .paddr  (paddr_c)
  );

  assign legal_c = (cause_c == CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'b00;
      rsp_paddr <= '0;
      wb_valid  <= 1'b0;
      wb_entry  <= '0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_fault <= !legal_c;
      rsp_cause <= cause_c;
      rsp_paddr <= legal_c ? paddr_c : '0;
      wb_valid  <= legal_c && changed_c;
      wb_entry  <= (legal_c && changed_c) ? entry_upd_c : '0;
    end
  end

endmodule

// File: rtl/pte_access_unit_chk.sv
module pte_access_unit_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_user,
  input logic [ADDR_W-1:0] req_entry,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [1:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_entry
);

  logic [ADDR_W-1:0] flag_mask;
  logic              unused_chk;
  assign flag_mask  = ADDR_W'(7'h60);
  assign unused_chk = ^req_vaddr[ADDR_W-1:PAGE_SHIFT];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !wb_valid));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R3
  absent_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_entry[0]) |=> (rsp_fault && rsp_cause == 2'b01));

  // R4
  wprot_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_entry[0] && req_write && !req_entry[1] &&
     !(req_user && !req_entry[2])) |=> (rsp_cause == 2'b10));

  // R5
  priv_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_entry[0] && req_user && !req_entry[2])
      |=> (rsp_fault && rsp_cause == 2'b11));

  // R6
  paddr_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault)
      |-> rsp_paddr[PAGE_SHIFT-1:0] == $past(req_vaddr[PAGE_SHIFT-1:0]));

  // R7
  wb_other_bits_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_entry[5] && ((wb_entry & ~flag_mask) ==
                  ($past(req_entry) & ~flag_mask))));

  // R8
  wb_only_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (rsp_valid && !rsp_fault));

  // R5
  fault_code_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00)));

endmodule

bind pte_access_unit pte_access_unit_chk #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
) i_chk (.*);

// File: tb/test_pte_access_unit.sv
module test_pte_access_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_user;
  logic [31:0] req_entry, req_vaddr;
  logic        rsp_valid, rsp_fault, wb_valid;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr, wb_entry;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  // Expected outputs for the request driven in the previous cycle
  logic        e_valid, e_fault, e_wb;
  logic [1:0]  e_cause;
  logic [31:0] e_paddr, e_entry;
  string       e_tag;

  always #5 clk = ~clk;

  pte_access_unit i_pte_access_unit (
    .clk, .rst, .req_valid, .req_write, .req_user, .req_entry, .req_vaddr,
    .rsp_valid, .rsp_fault, .rsp_cause, .rsp_paddr, .wb_valid, .wb_entry
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("R2 rsp_valid", 32'(rsp_valid), 32'(e_valid));
    cmp({e_tag, " rsp_fault"}, 32'(rsp_fault), 32'(e_fault));
    cmp({e_tag, " rsp_cause"}, 32'(rsp_cause), 32'(e_cause));
    cmp("R6 rsp_paddr", rsp_paddr, e_paddr);
    cmp("R8 wb_valid", 32'(wb_valid), 32'(e_wb));
    cmp("R7 wb_entry", wb_entry, e_entry);
  endtask

  // Behavioural model: compute what the next response must be
  task automatic model(input logic v, input logic w, input logic u,
                       input logic [31:0] ent, input logic [31:0] va,
                       input string tag);
    int cause;
    logic [31:0] upd;
    e_tag = tag;
    e_valid = v; e_fault = 0; e_cause = 0; e_paddr = 0; e_wb = 0; e_entry = 0;
    if (v) begin
      if (ent[0] == 0)                 cause = 1;
      else if (u && ent[2] == 0)       cause = 3;
      else if (w && ent[1] == 0)       cause = 2;
      else                             cause = 0;
      e_cause = 2'(cause);
      e_fault = (cause != 0);
      if (cause == 0) begin
        e_paddr = (ent & 32'hFFFF_F000) + (va % 4096);
        upd = ent;
        upd[5] = 1'b1;
        if (w) upd[6] = 1'b1;
        if (upd != ent) begin
          e_wb = 1;
          e_entry = upd;
        end
      end
    end
  endtask

  // One clock: check previous result, then drive next request at negedge
  task automatic step(input logic v, input logic w, input logic u,
                      input logic [31:0] ent, input logic [31:0] va,
                      input string tag);
    @(negedge clk);
    compare_all();
    req_valid = v; req_write = w; req_user = u; req_entry = ent; req_vaddr = va;
    model(v, w, u, ent, va, tag);
  endtask

  initial begin
    rst = 1'b1;
    req_valid = 0; req_write = 0; req_user = 0; req_entry = 0; req_vaddr = 0;
    // R1: drive a request during reset; outputs must still be zero
    @(negedge clk);
    req_valid = 1; req_entry = 32'hABCD_E007; req_vaddr = 32'h1234_5678;
    @(negedge clk);
    model(0, 0, 0, 0, 0, "R1");
    compare_all();
    rst = 1'b0;
    req_valid = 0;
    model(0, 0, 0, 0, 0, "R1");

    // R3: absent page, other bits all set, every access type
    step(1, 1, 1, 32'hFFFF_FFFE, 32'h0000_0ABC, "R3");
    step(1, 0, 0, 32'h1234_5066, 32'h0000_0001, "R3");
    // R4: write to read-only page, supervisor and permitted user
    step(1, 1, 0, 32'h0040_0001, 32'h0000_0100, "R4");
    step(1, 1, 1, 32'h0040_0005, 32'h0000_0100, "R4");
    // R5: user on supervisor page; privilege beats write protect
    step(1, 0, 1, 32'h0040_0003, 32'h0000_0200, "R5");
    step(1, 1, 1, 32'h0040_0001, 32'h0000_0200, "R5");
    // R9: supervisor ignores user bit, read ignores writable bit
    step(1, 0, 0, 32'h8000_0001, 32'hFFFF_FFFF, "R9");
    step(1, 0, 1, 32'h8000_0005, 32'h0000_0FFF, "R9");
    // R6 and R7: legal write sets both flags, keeps other bits
    step(1, 1, 1, 32'hCAFE_BF87, 32'hDEAD_BEEF, "R6");
    // R8: read of accessed page, write of accessed and dirty page: no write-back
    step(1, 0, 0, 32'h0001_0023, 32'h0000_0444, "R8");
    step(1, 1, 1, 32'h0001_0067, 32'h0000_0555, "R8");
    // R8: write of accessed but clean page must write back
    step(1, 1, 0, 32'h0001_0023, 32'h0000_0666, "R8");
    // R2: idle cycle
    step(0, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");

    // Random mix with idles, biased toward the permission bits
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ent;
      ent = $urandom;
      if (($urandom % 4) != 0) ent[0] = 1'b1;
      step(($urandom % 5) != 0, 1'($urandom), 1'($urandom), ent, $urandom, "R3");
    end
    step(0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    compare_all();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule